// File: doc/BRIEF.md
# Power-Good Window Monitor

This block produces the power-good flag for a single regulator channel. Each clock it receives a digitized feedback sample and a digitized soft-start sample, both in millivolts, and a fault-latched level from the channel's protection logic. It drives one active-high flag `pgood`. This flag stands for an open-drain pin: a 1 means the pin is released and a 0 means it is pulled down.

The flag stays low until the soft-start ramp has been seen at or above its threshold. After that, the feedback sample must sit inside a window around the reference for a qualification time before the flag goes high. The window is asymmetric: it extends 100 mV below the 900 mV reference and 135 mV above it. When the sample leaves the window, it must stay out for the same qualification time before the flag drops. This filter stops short load-step excursions from toggling the pin.

A latched protection fault, a synchronous reset, or the enable going low pulls the flag low and restarts the qualification. The thresholds and the filter time are parameters. The filter length in cycles is derived from the clock frequency.

Top module: `pgood_window_mon`

## Requirements
- R1: `pgood` is 0 until a clock edge samples `vss_mv` at or above `SS_THR_MV` (default 1500). Once that has happened, the soft-start condition stays satisfied until reset or until `en` goes low, even if `vss_mv` later falls.
- R2: A feedback sample counts as inside the window when `REF_MV-LO_OFS_MV <= vfb_mv <= REF_MV+HI_OFS_MV`. With the defaults this is 800 to 1035 inclusive. Both edge values are inside, and 799 and 1036 are outside.
- R3: While `pgood` is 1, it falls only after FILT_CYC consecutive clock edges sample `vfb_mv` outside the window. It falls at the FILT_CYC-th such edge. A shorter excursion has no effect. Any in-window sample restarts the count.
- R4: Once soft-start is satisfied, `pgood` rises only after FILT_CYC consecutive edges sample `vfb_mv` inside the window. The count starts with the edge after the one that satisfied soft-start. Any out-of-window sample restarts the count.
- R5: While `fault_lat` is 1, `pgood` is 0 in the same cycle. The qualification is cleared, so after `fault_lat` returns to 0 a fresh R4 qualification is needed.
- R6: When `rst` is 1 or `en` is 0 at a clock edge, `pgood` is 0 after that edge. The soft-start condition and the filter are both cleared.
- R7: FILT_CYC = CLK_KHZ*FILT_NS/1000000 cycles. This is 300 for the defaults (100 MHz, 3000 ns) and 750 at 250 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel enable; low forces the flag low |
| vfb_mv | input | MV_W | Feedback voltage sample, millivolts |
| vss_mv | input | MV_W | Soft-start voltage sample, millivolts |
| fault_lat | input | 1 | Protection fault latched for this channel |
| pgood | output | 1 | Power good, 1 = pin released, 0 = pulled down |

## Verification
The assertions assume the samples and `fault_lat` are stable levels that change only between clock edges. They also assume `fault_lat` is the only path that lowers the flag without a clock edge. The bench drives every input just after a falling edge and holds it for a whole cycle. It moves `fault_lat` only as a level, never as a glitch within a cycle. The bench begins with reset asserted, so no `$past` term sees values from before reset.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Inclusive window test on millivolt samples.
  function automatic logic in_window(input int sample, input int lo, input int hi);
    return (sample >= lo) && (sample <= hi);
  endfunction

  // Number of clock cycles in a time span given in nanoseconds.
  function automatic int cycles_from_ns(input longint clk_khz, input longint span_ns);
    return int'((clk_khz * span_ns) / 64'd1000000);
  endfunction

endpackage

// File: rtl/pgw_window_cmp.sv
module pgw_window_cmp #(
  parameter int MV_W  = 12,
  parameter int LO_MV = 800,
  parameter int HI_MV = 1035
) (
  input  logic [MV_W-1:0] vfb_mv,
  output logic            in_win
);
  import pgw_pkg::*;

  always_comb begin
    in_win = in_window(int'(vfb_mv), LO_MV, HI_MV);
  end

endmodule

// File: rtl/pgw_ss_gate.sv
module pgw_ss_gate #(
  parameter int MV_W      = 12,
  parameter int SS_THR_MV = 1500
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [MV_W-1:0] vss_mv,
  output logic            ss_done
);

  logic ss_hit;

  always_comb begin
    ss_hit = int'(vss_mv) >= SS_THR_MV;
  end

  // Sticky: once the ramp passes the threshold it stays satisfied.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ss_done <= 1'b0;
    end else if (ss_hit) begin
      ss_done <= 1'b1;
    end
  end

endmodule

// File: rtl/pgw_qual_filter.sv
module pgw_qual_filter #(
  parameter int FILT_CYC = 300,
  parameter int CNT_W    = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             in_win,
  output logic             qual,
  output logic [CNT_W-1:0] cnt
);

  logic mismatch;

  always_comb begin
    mismatch = (in_win != qual);
  end

  generate
    if (FILT_CYC <= 1) begin : g_direct
      // No filtering: the qualified state follows each sample.
      always_ff @(posedge clk) begin
        if (clr) begin
          qual <= 1'b0;
        end else begin
          qual <= in_win;
        end
      end
      always_comb begin
        cnt = '0;
      end
    end else begin : g_count
      localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_CYC - 1);
      always_ff @(posedge clk) begin
        if (clr) begin
          qual <= 1'b0;
          cnt  <= '0;
        end else if (!mismatch) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          qual <= in_win;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pgood_window_mon.sv
module pgood_window_mon #(
  parameter int MV_W      = 12,
  parameter int REF_MV    = 900,
  parameter int LO_OFS_MV = 100,
  parameter int HI_OFS_MV = 135,
  parameter int SS_THR_MV = 1500,
  parameter int CLK_KHZ   = 100000,
  parameter int FILT_NS   = 3000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [MV_W-1:0] vfb_mv,
  input  logic [MV_W-1:0] vss_mv,
  input  logic            fault_lat,
  output logic            pgood
);
  import pgw_pkg::*;

  localparam int LO_MV    = REF_MV - LO_OFS_MV;
  localparam int HI_MV    = REF_MV + HI_OFS_MV;
  localparam int FILT_CYC = cycles_from_ns(longint'(CLK_KHZ), longint'(FILT_NS));
  localparam int CNT_W    = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;

  // Named internal events, visible to the bound checker.
  logic             in_win;
  logic             ss_done;
  logic             filt_clr;
  logic             qual;
  logic [CNT_W-1:0] filt_cnt;

  pgw_window_cmp #(.MV_W(MV_W), .LO_MV(LO_MV), .HI_MV(HI_MV)) win_i (
    .vfb_mv (vfb_mv),
    .in_win (in_win)
  );

  pgw_ss_gate #(.MV_W(MV_W), .SS_THR_MV(SS_THR_MV)) ss_i (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .vss_mv  (vss_mv),
    .ss_done (ss_done)
  );

  always_comb begin
    filt_clr = rst || !en || fault_lat || !ss_done;
  end

  pgw_qual_filter #(.FILT_CYC(FILT_CYC), .CNT_W(CNT_W)) filt_i (
    .clk    (clk),
    .clr    (filt_clr),
    .in_win (in_win),
    .qual   (qual),
    .cnt    (filt_cnt)
  );

  always_comb begin
    pgood = qual && ss_done && !fault_lat;
  end

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int FILT_CYC = 300,
  parameter int CNT_W    = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             fault_lat,
  input logic             pgood,
  input logic             in_win,
  input logic             ss_done,
  input logic [CNT_W-1:0] filt_cnt
);

  AST_SS_BLOCK: assert property (@(posedge clk) disable iff (rst)
    !ss_done |-> !pgood); // R1

  AST_FAULT_LOW: assert property (@(posedge clk) disable iff (rst)
    fault_lat |-> !pgood); // R5

  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pgood); // R6

  AST_RISE_INSIDE: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> $past(in_win)); // R4

  AST_FALL_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    ($fell(pgood) && !fault_lat && $past(en) && !$past(fault_lat)) |-> !$past(in_win)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(filt_cnt) < ((FILT_CYC > 1) ? FILT_CYC : 1)); // R7

endmodule

bind pgood_window_mon pgw_checker #(.FILT_CYC(FILT_CYC), .CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .fault_lat (fault_lat),
  .pgood     (pgood),
  .in_win    (in_win),
  .ss_done   (ss_done),
  .filt_cnt  (filt_cnt)
);

// File: tb/pgood_window_mon_tb_top.sv
module pgood_window_mon_tb_top;

  localparam int W     = 12;
  localparam int KHZ   = 250000;
  localparam int QUALN = 750;   // R7: 250 MHz * 3 us

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] vfb_mv = '0;
  logic [W-1:0] vss_mv = '0;
  logic         fault_lat = 1'b0;
  logic         pgood;

  always #2 clk = ~clk;

  pgood_window_mon #(.MV_W(W), .CLK_KHZ(KHZ), .FILT_NS(3000)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .vfb_mv    (vfb_mv),
    .vss_mv    (vss_mv),
    .fault_lat (fault_lat),
    .pgood     (pgood)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t exp_q[$];
  int    n_vec  = 0;
  int    n_miss = 0;
  bit    done   = 0;

  // Bench-side reference state.
  bit m_ramp;   // soft-start seen
  bit m_good;   // qualified state
  int m_run;    // consecutive samples disagreeing with m_good

  function automatic bit inside_win(input int mv);
    int d;
    d = mv - 900;
    return !(d < -100 || d > 135);
  endfunction

  task automatic step(input logic r, input logic e, input int fb, input int ss,
                      input logic f, input string tag);
    item_t it;
    bit was_ramp;
    @(negedge clk);
    rst = r; en = e; vfb_mv = W'(fb); vss_mv = W'(ss); fault_lat = f;
    was_ramp = m_ramp;
    if (r || !e) begin
      m_ramp = 0; m_good = 0; m_run = 0;
    end else begin
      if (ss >= 1500) m_ramp = 1;
      if (f || !was_ramp) begin
        m_good = 0; m_run = 0;
      end else if (inside_win(fb) == m_good) begin
        m_run = 0;
      end else begin
        m_run++;
        if (m_run >= QUALN) begin
          m_good = !m_good;
          m_run  = 0;
        end
      end
    end
    it.exp = m_good && m_ramp && !f;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic hold(input int n, input int fb, input int ss, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, fb, ss, 1'b0, tag);
  endtask

  // Monitor: compare each cycle just after the rising edge.
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        it = exp_q.pop_front();
        n_vec++;
        if (pgood !== it.exp) begin
          n_miss++;
          $display("FAIL %s: pgood actual %0b expected %0b at %0t", it.tag, pgood, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    m_ramp = 0; m_good = 0; m_run = 0;
    // R6 reset state
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 900, 1600, 1'b0, "R6 reset");
    // R1: in window but ramp below threshold
    hold(900, 900, 1499, "R1 ramp low");
    // R4: ramp reaches exactly the threshold, then qualify
    hold(QUALN + 20, 900, 1500, "R4 rise after qual");
    // R1: ramp later drops, flag stays
    hold(30, 900, 200, "R1 sticky ramp");
    // R2: edge values inside
    hold(QUALN + 10, 800, 200, "R2 low edge 800");
    hold(QUALN + 10, 1035, 200, "R2 high edge 1035");
    // R3: short excursion at 799 ignored
    hold(QUALN - 1, 799, 200, "R3 short excursion 799");
    hold(5, 900, 200, "R3 back inside");
    // R3: broken excursions restart the count
    hold(500, 1036, 200, "R3 split excursion a");
    hold(3, 1000, 200, "R3 split gap");
    hold(500, 1036, 200, "R3 split excursion b");
    // R3 / R7: full-length excursion at 1036 drops at cycle 750
    hold(QUALN + 10, 1036, 200, "R3 R7 drop 1036");
    // R4: interrupted re-qualification
    hold(400, 900, 200, "R4 partial inside");
    hold(2, 1100, 200, "R4 interrupt");
    hold(QUALN + 5, 900, 200, "R4 requalify");
    // R5: fault pulls low immediately, then fresh qualification
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 900, 200, 1'b1, "R5 fault low");
    hold(QUALN + 5, 900, 200, "R5 requal after fault");
    // R6: enable low clears; ramp needed again
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 900, 1600, 1'b0, "R6 enable low");
    hold(300, 900, 1000, "R6 R1 ramp again low");
    hold(QUALN + 5, 900, 1600, "R6 R4 re-enable");
    // R6: reset in the middle of good
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 900, 1600, 1'b0, "R6 reset mid");
    hold(10, 900, 1600, "R6 after reset");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end

endmodule